// File: doc/BRIEF.md
# Quad SPI Interrupt Status and Gating Unit

This block collects the event conditions of a quad SPI controller and merges them into one interrupt line. It watches the fill levels of the transmit and receive FIFOs and derives empty, full and threshold events from them, and it takes single-cycle pulses for descriptor completion, packet completion, DMA error and controller soft reset. Each event that is armed latches into a sticky status bit.

There are two gates between an event and the interrupt pin. The enable register decides whether an event is recorded at all. The signal-enable register decides which recorded bits drive the line. Software acknowledges an event by clearing its enable bit, which also clears the latched status. Setting the bit again re-arms the event, so a condition that still holds is recorded again at once. A 5-bit programmable threshold per direction sets the level at which each threshold event fires. Registers are reached through a plain single-cycle write port and a combinational read port.

Top module: `sqi_irq_ctrl`

## Requirements
- R1: After reset the enable, status, signal-enable and threshold registers read 0 and `irq` is low.
- R2: Event bits are shared by the enable, status and signal-enable registers: TX empty 0, TX full 1, TX threshold 2, RX empty 3, RX full 4, RX threshold 5, descriptor done 9, packet complete 10, DMA error 11. Every other bit always reads 0. Register word addresses are enable 0, status 1, signal-enable 2 and threshold 3.
- R3: An empty event holds while a FIFO level is 0. A full event holds while a level equals DEPTH, which is 16 by default.
- R4: The threshold register holds the TX threshold in bits 12:8 and the RX threshold in bits 4:0. The TX threshold event holds while the TX level is at or below the TX threshold. The RX threshold event holds while the RX level is at or above the RX threshold.
- R5: A status bit that is set stays set after its condition goes away, for as long as its enable bit stays 1.
- R6: An event whose enable bit is 0 does not set its status bit.
- R7: Writing 0 to an enable bit clears the matching status bit at the edge of that write. Writing 1 re-arms the bit, and it is set at the same edge if the condition holds.
- R8: `irq` is high exactly when some bit is 1 in status, enable and signal-enable together.
- R9: Reading registers has no side effect. Writes to the status address are ignored.
- R10: A `soft_rst` pulse raises both the TX empty event and the RX empty event.
- R11: The `desc_done`, `pkt_done` and `dma_err` pulses set status bits 9, 10 and 11 when those bits are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tx_level | input | LW (5) | TX FIFO fill level |
| rx_level | input | LW (5) | RX FIFO fill level |
| desc_done | input | 1 | Descriptor finished pulse |
| pkt_done | input | 1 | Packet finished pulse |
| dma_err | input | 1 | DMA error pulse |
| soft_rst | input | 1 | Controller soft reset pulse |
| irq | output | 1 | Combined interrupt line |

## Verification
The level events are swept with every FIFO level from 0 to 16 against several threshold values, including 0 and 31. This covers the at-or-below and at-or-above boundaries and the full and empty edges. Separate sequences acknowledge and re-arm an event while its condition still holds, and toggle the signal-enable bits over a recorded event. These separate recording from reporting and show that the status bit stays latched. The pulse sources are fired once with their enable bit off and once with it on. Writes aimed at the status address are also tried, to show that they change nothing.

// File: rtl/sqi_irq_pkg.sv
package sqi_irq_pkg;
  localparam int NEV = 12;
  localparam int B_TXE  = 0;
  localparam int B_TXF  = 1;
  localparam int B_TXT  = 2;
  localparam int B_RXE  = 3;
  localparam int B_RXF  = 4;
  localparam int B_RXT  = 5;
  localparam int B_DESC = 9;
  localparam int B_PKT  = 10;
  localparam int B_ERR  = 11;
  localparam logic [NEV-1:0] EV_MASK = 12'hE3F;
  localparam int THR_W = 5;
  localparam int TX_THR_LSB = 8;
  typedef enum logic [1:0] {
    A_EN   = 2'd0,
    A_STAT = 2'd1,
    A_SIG  = 2'd2,
    A_THR  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/sqi_evt_detect.sv
module sqi_evt_detect
  import sqi_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic [LW-1:0]    tx_level,
  input  logic [LW-1:0]    rx_level,
  input  logic [THR_W-1:0] tx_thr,
  input  logic [THR_W-1:0] rx_thr,
  input  logic             desc_done,
  input  logic             pkt_done,
  input  logic             dma_err,
  input  logic             soft_rst,
  output logic [NEV-1:0]   ev
);
  int unsigned txl, rxl, txt, rxt;

  always_comb begin
    txl = int'(tx_level);
    rxl = int'(rx_level);
    txt = int'(tx_thr);
    rxt = int'(rx_thr);
    ev = '0;
    ev[B_TXE]  = (txl == 0) | soft_rst;
    ev[B_TXF]  = (txl == DEPTH);
    ev[B_TXT]  = (txl <= txt);
    ev[B_RXE]  = (rxl == 0) | soft_rst;
    ev[B_RXF]  = (rxl == DEPTH);
    ev[B_RXT]  = (rxl >= rxt);
    ev[B_DESC] = desc_done;
    ev[B_PKT]  = pkt_done;
    ev[B_ERR]  = dma_err;
  end
endmodule

// File: rtl/sqi_irq_regs.sv
module sqi_irq_regs
  import sqi_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic [NEV-1:0]   ev,
  output logic [NEV-1:0]   en_q,
  output logic [NEV-1:0]   st_q,
  output logic [NEV-1:0]   sg_q,
  output logic [THR_W-1:0] tx_thr,
  output logic [THR_W-1:0] rx_thr,
  output logic [31:0]      reg_rdata
);
  logic [NEV-1:0] en_d, st_d;
  logic           wr_en, wr_sg, wr_thr;

  assign wr_en  = reg_wr && (reg_addr == A_EN);
  assign wr_sg  = reg_wr && (reg_addr == A_SIG);
  assign wr_thr = reg_wr && (reg_addr == A_THR);

  always_comb begin
    en_d = wr_en ? (reg_wdata[NEV-1:0] & EV_MASK) : en_q;
    st_d = (st_q | ev) & en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      st_q   <= '0;
      sg_q   <= '0;
      tx_thr <= '0;
      rx_thr <= '0;
    end else begin
      en_q <= en_d;
      st_q <= st_d;
      if (wr_sg) sg_q <= reg_wdata[NEV-1:0] & EV_MASK;
      if (wr_thr) begin
        tx_thr <= reg_wdata[TX_THR_LSB +: THR_W];
        rx_thr <= reg_wdata[THR_W-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_EN:   reg_rdata[NEV-1:0] = en_q;
      A_STAT: reg_rdata[NEV-1:0] = st_q;
      A_SIG:  reg_rdata[NEV-1:0] = sg_q;
      default: begin
        reg_rdata[TX_THR_LSB +: THR_W] = tx_thr;
        reg_rdata[THR_W-1:0]           = rx_thr;
      end
    endcase
  end
endmodule

// File: rtl/sqi_irq_gate.sv
module sqi_irq_gate
  import sqi_irq_pkg::*;
(
  input  logic [NEV-1:0] st,
  input  logic [NEV-1:0] en,
  input  logic [NEV-1:0] sg,
  output logic           irq
);
  logic [NEV-1:0] hit;
  for (genvar i = 0; i < NEV; i++) begin : g_bit
    assign hit[i] = st[i] & en[i] & sg[i];
  end
  assign irq = |hit;
endmodule

// File: rtl/sqi_irq_ctrl.sv
module sqi_irq_ctrl
  import sqi_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic          desc_done,
  input  logic          pkt_done,
  input  logic          dma_err,
  input  logic          soft_rst,
  output logic          irq
);
  logic [NEV-1:0]   ev, en_q, st_q, sg_q;
  logic [THR_W-1:0] tx_thr, rx_thr;

  sqi_evt_detect #(.DEPTH(DEPTH)) u_det (
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_thr(tx_thr), .rx_thr(rx_thr),
    .desc_done(desc_done), .pkt_done(pkt_done),
    .dma_err(dma_err), .soft_rst(soft_rst), .ev(ev)
  );

  sqi_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ev(ev), .en_q(en_q), .st_q(st_q),
    .sg_q(sg_q), .tx_thr(tx_thr), .rx_thr(rx_thr), .reg_rdata(reg_rdata)
  );

  sqi_irq_gate u_gate (.st(st_q), .en(en_q), .sg(sg_q), .irq(irq));
endmodule

// File: rtl/sqi_irq_checker.sv
module sqi_irq_checker
  import sqi_irq_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [1:0]     reg_addr,
  input logic           dma_err,
  input logic           soft_rst,
  input logic [NEV-1:0] en_q,
  input logic [NEV-1:0] st_q,
  input logic [NEV-1:0] sg_q,
  input logic           irq
);
  logic en_write;
  assign en_write = reg_wr && (reg_addr == A_EN);

  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q | en_q | sg_q) & ~EV_MASK) == '0);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !en_write |=> ((st_q & $past(st_q)) == $past(st_q)));

  a_r6_gated_record: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q & ~en_q) == '0);

  a_r8_irq_two_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(st_q & en_q & sg_q));

  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && en_q[B_TXE] && en_q[B_RXE] && !en_write) |=> (st_q[B_TXE] && st_q[B_RXE]));

  a_r11_dma_error: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_err && en_q[B_ERR] && !en_write) |=> st_q[B_ERR]);
endmodule

bind sqi_irq_ctrl sqi_irq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .dma_err(dma_err), .soft_rst(soft_rst),
  .en_q(en_q), .st_q(st_q), .sg_q(sg_q), .irq(irq)
);

// File: tb/tb_sqi_irq_ctrl.sv
module tb_sqi_irq_ctrl;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic          clk = 0;
  logic          rst_n = 0;
  logic          reg_wr = 0;
  logic [1:0]    reg_addr = 0;
  logic [31:0]   reg_wdata = 0;
  logic [31:0]   reg_rdata;
  logic [LW-1:0] tx_level = 5;
  logic [LW-1:0] rx_level = 5;
  logic desc_done = 0, pkt_done = 0, dma_err = 0, soft_rst = 0;
  logic irq;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  sqi_irq_ctrl #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: desc_done = 1; 1: pkt_done = 1; 2: dma_err = 1; default: soft_rst = 1;
    endcase
    @(negedge clk);
    desc_done = 0; pkt_done = 0; dma_err = 0; soft_rst = 0;
  endtask

  function automatic logic [31:0] lvl_exp(int tl, int rl, int tt, int rt);
    logic [31:0] e = 0;
    e[0] = (tl == 0);  e[1] = (tl == DEPTH); e[2] = (tl <= tt);
    e[3] = (rl == 0);  e[4] = (rl == DEPTH); e[5] = (rl >= rt);
    return e;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(a[1:0], d); chk("R1 reset reg", d, 0); end
    chk("R1 reset irq", {31'd0, irq}, 0);

    // R3 R4 sweep of levels against thresholds
    for (int ti = 0; ti < 4; ti++) begin
      int th = (ti == 0) ? 0 : (ti == 1) ? 4 : (ti == 2) ? 16 : 31;
      wr(3, (th << 8) | th);
      rd(3, d); chk("R4 thr readback", d, (th << 8) | th);
      for (int l = 0; l <= DEPTH; l++) begin
        tx_level = l[LW-1:0]; rx_level = l[LW-1:0];
        wr(0, 0);
        wr(0, 32'h3F);
        rd(1, d); chk("R3/R4 level events", d, lvl_exp(l, l, th, th));
      end
    end

    // R4 asymmetric thresholds: tx 3, rx 9
    wr(3, (3 << 8) | 9);
    tx_level = 3; rx_level = 9; wr(0, 0); wr(0, 32'h3F);
    rd(1, d); chk("R4 tx at thr, rx at thr", d, 32'h24);
    tx_level = 4; rx_level = 8; wr(0, 0); wr(0, 32'h3F);
    rd(1, d); chk("R4 tx above, rx below", d, 32'h00);

    // R5 sticky
    tx_level = 0; rx_level = 5; wr(3, 0); wr(0, 0); wr(0, 32'h1);
    tx_level = 7; repeat (4) @(negedge clk);
    rd(1, d); chk("R5 sticky after condition gone", d, 32'h1);

    // R7 acknowledge and re-arm while condition holds
    tx_level = 0;
    wr(0, 0); rd(1, d); chk("R7 clear on enable 0", d, 0);
    wr(0, 1); rd(1, d); chk("R7 re-arm sets again", d, 32'h1);
    tx_level = 7; wr(0, 0); wr(0, 1); rd(1, d); chk("R7 re-arm no condition", d, 0);

    // R6 disabled event not recorded, R11 pulses
    wr(0, 0);
    pulse(0); pulse(1); pulse(2);
    rd(1, d); chk("R6 pulses disabled", d, 0);
    wr(0, 32'hE00);
    pulse(0); rd(1, d); chk("R11 desc done bit9", d, 32'h200);
    pulse(1); rd(1, d); chk("R11 pkt done bit10", d, 32'h600);
    pulse(2); rd(1, d); chk("R11 dma err bit11", d, 32'hE00);

    // R8 signal-enable gating
    chk("R8 no sig irq low", {31'd0, irq}, 0);
    wr(2, 32'h400); #1 chk("R8 sig pkt irq high", {31'd0, irq}, 1);
    wr(0, 32'hA00); #1 chk("R8 enable off irq low", {31'd0, irq}, 0);
    rd(1, d); chk("R8 status after mask", d, 32'hA00);
    wr(2, 32'hFFFFFFFF); #1 chk("R8 all sig irq high", {31'd0, irq}, 1);
    rd(2, d); chk("R2 sig unused bits zero", d, 32'hE3F);

    // R9 status write ignored, reads repeatable
    wr(1, 32'h0); rd(1, d); chk("R9 status write ignored", d, 32'hA00);
    rd(1, d); chk("R9 read no side effect", d, 32'hA00);

    // R2 unused bits of enable stay 0
    wr(0, 32'hFFFFFFFF); rd(0, d); chk("R2 enable unused bits zero", d, 32'hE3F);

    // R10 soft reset raises both empty events
    wr(2, 0); tx_level = 5; rx_level = 5; wr(3, 0);
    wr(0, 0); wr(0, 32'h9);
    rd(1, d); chk("R10 before soft reset", d, 0);
    pulse(3); rd(1, d); chk("R10 soft reset empty bits", d, 32'h9);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule